// File: doc/BRIEF.md
# Memory-Card Command Issue Sequencer

This block is the command path of a memory-card host controller. Software writes a 32-bit argument and then a command word through a small register port. Bit 31 of the command word starts the command. The block then sends the command index and argument to an abstract card-side channel and waits for the reply. The reply carries a length code and a 128-bit payload. The block stores the payload in four 32-bit response registers and sets either a command-complete flag or a no-response flag in a sticky raw status register.

The block also keeps a transfer counter. Writing the byte-count register loads this counter, and each 32-bit data-port access lowers it. When the counter reaches zero and the current command word asks for an automatic stop, the block issues a stop command by itself (index 12, argument 0). The software-visible command and argument registers keep their values through this stop.

Top module: `sdcmd_seq`

## Requirements
- R1: After reset, block size (address 2) and byte count (address 3) read 0x200. The transfer counter (address 5), raw status (address 4) and all four response words (addresses 8 to 11) read 0.
- R2: A write to the command register (address 0) with bit 31 set starts a command. The request carries command bits 5:0 as the index and the argument register (address 1) as the argument, and holds both stable until it is accepted. The command register then reads back with bit 31 clear.
- R3: If bit 21 of the loaded command is set, no request is sent, and status bit 2 (command-complete) is set in the cycle after the write.
- R4: With bit 6 set and bit 7 clear, a reply of length code 1 (4 bytes) sets status bit 2. It puts payload bytes 0 to 3 into response word 0 in big-endian order, byte 0 being payload bits 127:120, and zeroes words 1 to 3.
- R5: With bits 6 and 7 set, a reply of length code 2 (16 bytes) sets status bit 2. Word 0 gets bytes 12 to 15, word 1 bytes 8 to 11, word 2 bytes 4 to 7 and word 3 bytes 0 to 3, each word big-endian.
- R6: Length code 3 (card failure), or a length that does not match bit 7 while bit 6 is set, sets status bit 1 (no-response) and not bit 2. The response words stay unchanged.
- R7: A write to the byte count loads both the byte count and the transfer counter. Each data-port strobe lowers the counter by 4 and never takes it below zero. Every strobe that leaves it at zero sets status bit 3.
- R8: When bit 12 of the command word is set and the transfer counter is zero, the block issues index 12 with argument 0. This happens at the end of a command or on a strobe that leaves the counter at zero. After that reply, status bit 14 is set, and the command and argument registers hold their earlier values.
- R9: While `cmd_busy` is high, writes to the command and argument registers are ignored.
- R10: Writing the status register clears each bit written as one and leaves the other bits unchanged.
- R11: With bit 6 clear, a reply of length code 0 sets status bit 2 and leaves the response words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| data_strobe | input | 1 | One 32-bit data-port access |
| cmd_busy | output | 1 | Command or stop in flight or pending |
| cc_req_valid | output | 1 | Card request valid |
| cc_req_ready | input | 1 | Card request accepted |
| cc_req_index | output | 6 | Command index |
| cc_req_arg | output | 32 | Command argument |
| cc_rsp_valid | input | 1 | Card reply valid |
| cc_rsp_len | input | 2 | 0 none, 1 four bytes, 2 sixteen bytes, 3 failure |
| cc_rsp_data | input | 128 | Reply payload, byte 0 in bits 127:120 |

## Verification
The assertions rely on the card side behaving correctly. It raises `cc_rsp_valid` only after it has accepted a request, and it never sends a reply while no request is outstanding. The assertions also assume that software writes the command register only while `cmd_busy` is low, except in the deliberate test where a blocked write is checked. The bench card model follows these rules. It waits for `cc_req_valid` before it asserts ready, and it sends exactly one reply, one cycle wide, after each accepted request. Data strobes and register writes are never driven in the same cycle as a reply.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

    // Command word bit positions (decoded by the sequencer)
    localparam int B_LOAD      = 31;
    localparam int B_CLK_ONLY  = 21;
    localparam int B_AUTO_STOP = 12;
    localparam int B_LONG_RSP  = 7;
    localparam int B_RSP_EN    = 6;
    localparam int IDX_BITS    = 6;

    // Raw status bit positions
    localparam int ST_NORSP = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_DATA  = 3;
    localparam int ST_ASTOP = 14;

    // Register addresses
    localparam logic [3:0] A_CMD     = 4'd0;
    localparam logic [3:0] A_ARG     = 4'd1;
    localparam logic [3:0] A_BLKSZ   = 4'd2;
    localparam logic [3:0] A_BYTECNT = 4'd3;
    localparam logic [3:0] A_STATUS  = 4'd4;
    localparam logic [3:0] A_XFER    = 4'd5;
    localparam logic [3:0] A_RESP0   = 4'd8;

    localparam logic [IDX_BITS-1:0] STOP_INDEX = 6'd12;
    localparam logic [31:0]         SIZE_RST   = 32'h200;

    typedef enum logic [1:0] {
        RLEN_NONE = 2'd0,
        RLEN_4    = 2'd1,
        RLEN_16   = 2'd2,
        RLEN_ERR  = 2'd3
    } rsp_len_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_RSP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                auto_stop;
        logic                long_rsp;
        logic                rsp_en;
        logic [IDX_BITS-1:0] index;
    } cmd_fields_t;

    function automatic cmd_fields_t decode_cmd(input logic [31:0] w);
        cmd_fields_t f;
        f.auto_stop = w[B_AUTO_STOP];
        f.long_rsp  = w[B_LONG_RSP];
        f.rsp_en    = w[B_RSP_EN];
        f.index     = w[IDX_BITS-1:0];
        return f;
    endfunction

endpackage

// File: rtl/sdcs_resp_unpack.sv
module sdcs_resp_unpack
    import sdcs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                           rsp_en_i,
    input  logic                           long_i,
    input  rsp_len_e                       len_i,
    input  logic [NWORDS*WORD_W-1:0]       payload_i,
    output logic                           ok_o,
    output logic                           store_o,
    output logic [NWORDS-1:0][WORD_W-1:0]  words_o
);
    localparam int PAY_W = NWORDS * WORD_W;

    logic len_match;

    always_comb begin
        len_match = long_i ? (len_i == RLEN_16) : (len_i == RLEN_4);
        ok_o      = (len_i != RLEN_ERR) && (!rsp_en_i || len_match);
        store_o   = ok_o && rsp_en_i;
    end

    // Long: word g takes the g-th 32-bit slice from the payload tail.
    // Short: word 0 takes the leading four bytes, the rest are zero.
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        if (g == 0) begin : g_first
            assign words_o[g] = long_i ? payload_i[WORD_W-1:0]
                                       : payload_i[PAY_W-1 -: WORD_W];
        end else begin : g_rest
            assign words_o[g] = long_i ? payload_i[g*WORD_W +: WORD_W] : '0;
        end
    end

endmodule

// File: rtl/sdcs_xfer_counter.sv
module sdcs_xfer_counter #(
    parameter int CNT_W = 32,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_zero_o
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt        = (count_o > STEP_V) ? count_o - STEP_V : '0;
        hit_zero_o = dec_i && !load_i && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)         count_o <= '0;
        else if (load_i) count_o <= load_val_i;
        else if (dec_i)  count_o <= nxt;
    end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int NRESP     = 4,
    parameter int STEP_BYTE = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr_en,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wr_data,
    input  logic [ADDR_W-1:0]         reg_rd_addr,
    output logic [DATA_W-1:0]         reg_rd_data,
    input  logic                      data_strobe,
    output logic                      cmd_busy,
    output logic                      cc_req_valid,
    input  logic                      cc_req_ready,
    output logic [IDX_BITS-1:0]       cc_req_index,
    output logic [DATA_W-1:0]         cc_req_arg,
    input  logic                      cc_rsp_valid,
    input  logic [1:0]                cc_rsp_len,
    input  logic [NRESP*DATA_W-1:0]   cc_rsp_data
);
    localparam int PAY_W = NRESP * DATA_W;

    logic [DATA_W-1:0]             cmd_q, arg_q, blksz_q, bytecnt_q, status_q;
    logic [NRESP-1:0][DATA_W-1:0]  resp_q;
    seq_state_e                    state_q;
    logic                          stop_phase_q, stop_pend_q;

    cmd_fields_t                   cf;
    logic                          wr_hit_cmd, wr_hit_arg, wr_hit_cnt;
    logic                          clk_load, rsp_fire;
    logic                          rsp_ok, rsp_store;
    logic [NRESP-1:0][DATA_W-1:0]  rsp_words;
    logic [DATA_W-1:0]             xfer_cnt;
    logic                          xfer_zero, hit_zero;
    logic [DATA_W-1:0]             st_set, st_clr;

    assign cf        = decode_cmd(cmd_q);
    assign cmd_busy  = (state_q != SQ_IDLE) || stop_pend_q;
    assign xfer_zero = (xfer_cnt == '0);

    assign wr_hit_cmd = reg_wr_en && (reg_addr == A_CMD) && !cmd_busy;
    assign wr_hit_arg = reg_wr_en && (reg_addr == A_ARG) && !cmd_busy;
    assign wr_hit_cnt = reg_wr_en && (reg_addr == A_BYTECNT);
    assign clk_load   = wr_hit_cmd && reg_wr_data[B_LOAD] && reg_wr_data[B_CLK_ONLY];
    assign rsp_fire   = (state_q == SQ_RSP) && cc_rsp_valid;

    assign cc_req_valid = (state_q == SQ_REQ);
    assign cc_req_index = stop_phase_q ? STOP_INDEX : cf.index;
    assign cc_req_arg   = stop_phase_q ? '0 : arg_q;

    sdcs_resp_unpack #(.WORD_W(DATA_W), .NWORDS(NRESP)) u_unpack (
        .rsp_en_i  (cf.rsp_en),
        .long_i    (cf.long_rsp),
        .len_i     (rsp_len_e'(cc_rsp_len)),
        .payload_i (cc_rsp_data[PAY_W-1:0]),
        .ok_o      (rsp_ok),
        .store_o   (rsp_store),
        .words_o   (rsp_words)
    );

    sdcs_xfer_counter #(.CNT_W(DATA_W), .STEP(STEP_BYTE)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_hit_cnt),
        .load_val_i (reg_wr_data),
        .dec_i      (data_strobe),
        .count_o    (xfer_cnt),
        .hit_zero_o (hit_zero)
    );

    always_comb begin
        st_set = '0;
        if (rsp_fire) begin
            st_set[ST_DONE]  = rsp_ok;
            st_set[ST_NORSP] = !rsp_ok;
            st_set[ST_ASTOP] = stop_phase_q;
        end
        if (clk_load) st_set[ST_DONE] = 1'b1;
        if (hit_zero) st_set[ST_DATA] = 1'b1;
        st_clr = (reg_wr_en && (reg_addr == A_STATUS)) ? reg_wr_data : '0;
    end

    // Register file
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            arg_q     <= '0;
            blksz_q   <= SIZE_RST;
            bytecnt_q <= SIZE_RST;
            status_q  <= '0;
            resp_q    <= '0;
        end else begin
            status_q <= (status_q & ~st_clr) | st_set;
            if (wr_hit_cmd) begin
                cmd_q         <= reg_wr_data;
                cmd_q[B_LOAD] <= 1'b0;
            end
            if (wr_hit_arg) arg_q <= reg_wr_data;
            if (wr_hit_cnt) bytecnt_q <= reg_wr_data;
            if (reg_wr_en && (reg_addr == A_BLKSZ)) blksz_q <= reg_wr_data;
            if (rsp_fire && rsp_store) resp_q <= rsp_words;
        end
    end

    // Issue sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            stop_phase_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (stop_pend_q) begin
                        state_q      <= SQ_REQ;
                        stop_phase_q <= 1'b1;
                        stop_pend_q  <= 1'b0;
                    end else if (wr_hit_cmd && reg_wr_data[B_LOAD]) begin
                        if (reg_wr_data[B_CLK_ONLY]) begin
                            if (reg_wr_data[B_AUTO_STOP] && xfer_zero)
                                stop_pend_q <= 1'b1;
                        end else begin
                            state_q      <= SQ_REQ;
                            stop_phase_q <= 1'b0;
                        end
                    end
                end
                SQ_REQ: if (cc_req_ready) state_q <= SQ_RSP;
                SQ_RSP: begin
                    if (cc_rsp_valid) begin
                        state_q      <= SQ_IDLE;
                        stop_phase_q <= 1'b0;
                        if (!stop_phase_q && cf.auto_stop && xfer_zero)
                            stop_pend_q <= 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
            if (hit_zero && cf.auto_stop) stop_pend_q <= 1'b1;
        end
    end

    // Read mux
    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_addr)
            A_CMD:     reg_rd_data = cmd_q;
            A_ARG:     reg_rd_data = arg_q;
            A_BLKSZ:   reg_rd_data = blksz_q;
            A_BYTECNT: reg_rd_data = bytecnt_q;
            A_STATUS:  reg_rd_data = status_q;
            A_XFER:    reg_rd_data = xfer_cnt;
            default:   reg_rd_data = '0;
        endcase
        for (int i = 0; i < NRESP; i++) begin
            if (reg_rd_addr == ADDR_W'(A_RESP0 + i)) reg_rd_data = resp_q[i];
        end
    end

endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              cmd_busy,
    input logic              cc_req_valid,
    input logic              cc_req_ready,
    input logic [5:0]        cc_req_index,
    input logic [DATA_W-1:0] cc_req_arg,
    input logic              cc_rsp_valid,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] cmd_q,
    input logic [DATA_W-1:0] xfer_cnt
);
    // R2: request held stable until accepted
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        cc_req_valid && !cc_req_ready |=>
            cc_req_valid && $stable(cc_req_index) && $stable(cc_req_arg));

    // R2: stored command word never keeps the start bit
    assert_load_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_q[31]);

    // R9: an outstanding request implies busy
    assert_req_busy_R9: assert property (@(posedge clk) disable iff (rst)
        cc_req_valid |-> cmd_busy);

    // R6: one reply never raises both outcomes
    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[1]) |-> !$rose(status_q[2]));

    // R7: transfer counter only grows on a byte-count write
    assert_cnt_mono_R7: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_addr == 4'd3) |=> xfer_cnt <= $past(xfer_cnt));

    // R8: stop-done only follows a card reply
    assert_astop_reply_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[14]) |-> $past(cc_rsp_valid));

endmodule

bind sdcmd_seq sdcmd_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .cmd_busy     (cmd_busy),
    .cc_req_valid (cc_req_valid),
    .cc_req_ready (cc_req_ready),
    .cc_req_index (cc_req_index),
    .cc_req_arg   (cc_req_arg),
    .cc_rsp_valid (cc_rsp_valid),
    .status_q     (status_q),
    .cmd_q        (cmd_q),
    .xfer_cnt     (xfer_cnt)
);

// File: tb/sdcmd_seq_tb.sv
module sdcmd_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [3:0]   reg_rd_addr = '0;
    logic [31:0]  reg_rd_data;
    logic         data_strobe = 1'b0;
    logic         cmd_busy;
    logic         cc_req_valid;
    logic         cc_req_ready = 1'b0;
    logic [5:0]   cc_req_index;
    logic [31:0]  cc_req_arg;
    logic         cc_rsp_valid = 1'b0;
    logic [1:0]   cc_rsp_len = '0;
    logic [127:0] cc_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sdcmd_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .data_strobe(data_strobe),
        .cmd_busy(cmd_busy), .cc_req_valid(cc_req_valid),
        .cc_req_ready(cc_req_ready), .cc_req_index(cc_req_index),
        .cc_req_arg(cc_req_arg), .cc_rsp_valid(cc_rsp_valid),
        .cc_rsp_len(cc_rsp_len), .cc_rsp_data(cc_rsp_data)
    );

    localparam int NV = 6;
    localparam logic [31:0] V_CMD [NV] = '{32'h80000051, 32'h800000C2,
        32'h800000C9, 32'h80000000, 32'h80000007, 32'h80000048};
    localparam logic [31:0] V_ARG [NV] = '{32'hA5A50001, 32'h0, 32'h77,
        32'h5, 32'hFFFF0000, 32'h3};
    localparam logic [1:0]  V_LEN [NV] = '{2'd1, 2'd2, 2'd1, 2'd3, 2'd0, 2'd2};
    localparam logic [127:0] V_DAT [NV] = '{
        128'hDEADBEEF_01020304_05060708_090A0B0C,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h11111111_22222222_33333333_44444444,
        128'h0, 128'hABCDEF00_0, 128'h5};
    localparam logic [31:0] V_ST [NV] = '{32'h4, 32'h4, 32'h2, 32'h2, 32'h4, 32'h2};
    localparam logic [127:0] V_RSP [NV] = '{
        128'h00000000_00000000_00000000_DEADBEEF,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h00112233_44556677_8899AABB_CCDDEEFF};
    localparam string V_TAG [NV] = '{"R4", "R5", "R6", "R6", "R11", "R6"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic strobe();
        @(negedge clk);
        data_strobe = 1'b1;
        @(negedge clk);
        data_strobe = 1'b0;
    endtask

    task automatic wait_req(input string tag, output logic [5:0] idx,
                            output logic [31:0] arg);
        int n = 0;
        while (!cc_req_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!cc_req_valid) begin
            errors++;
            $display("FAIL %s request valid actual=0 expected=1", tag);
        end
        idx = cc_req_index;
        arg = cc_req_arg;
    endtask

    task automatic reply(input logic [1:0] len, input logic [127:0] dat);
        cc_req_ready = 1'b1;
        @(negedge clk);
        cc_req_ready = 1'b0;
        cc_rsp_valid = 1'b1; cc_rsp_len = len; cc_rsp_data = dat;
        @(negedge clk);
        cc_rsp_valid = 1'b0;
    endtask

    task automatic no_req(input string tag, input int n);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cc_req_valid) seen = 1;
        end
        check(tag, "spurious request", 32'(seen), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0]  idx;
        logic [31:0] arg;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd2, v); check("R1", "block size", v, 32'h200);
        rd(4'd3, v); check("R1", "byte count", v, 32'h200);
        rd(4'd5, v); check("R1", "transfer counter", v, 32'h0);
        rd(4'd4, v); check("R1", "status", v, 32'h0);
        for (int w = 0; w < 4; w++) begin
            rd(4'(8 + w), v); check("R1", "response", v, 32'h0);
        end

        // Table walk: R2 request fields, R4/R5/R6/R11 outcomes
        for (int i = 0; i < NV; i++) begin
            wr(4'd4, 32'hFFFFFFFF);
            wr(4'd1, V_ARG[i]);
            wr(4'd0, V_CMD[i]);
            wait_req("R2", idx, arg);
            check("R2", "index", 32'(idx), 32'(V_CMD[i][5:0]));
            check("R2", "argument", arg, V_ARG[i]);
            reply(V_LEN[i], V_DAT[i]);
            rd(4'd4, v); check(V_TAG[i], "status", v, V_ST[i]);
            for (int w = 0; w < 4; w++) begin
                rd(4'(8 + w), v);
                check(V_TAG[i], "response word", v, V_RSP[i][w*32 +: 32]);
            end
            rd(4'd0, v); check("R2", "cmd readback", v, V_CMD[i] & 32'h7FFFFFFF);
        end

        // R3 clock-change only
        wr(4'd4, 32'hFFFFFFFF);
        wr(4'd0, 32'h80200003);
        rd(4'd4, v); check("R3", "complete flag", v, 32'h4);
        no_req("R3", 6);

        // R7 counter load, step, saturation
        wr(4'd3, 32'd6);
        rd(4'd3, v); check("R7", "byte count", v, 32'd6);
        rd(4'd5, v); check("R7", "counter loaded", v, 32'd6);
        strobe();
        rd(4'd5, v); check("R7", "counter after one", v, 32'd2);
        rd(4'd4, v); check("R7", "no data flag yet", v, 32'h4);
        strobe();
        rd(4'd5, v); check("R7", "counter zero", v, 32'd0);
        rd(4'd4, v); check("R7", "data flag", v, 32'hC);
        wr(4'd4, 32'h8);
        rd(4'd4, v); check("R10", "selective clear", v, 32'h4);
        strobe();
        rd(4'd5, v); check("R7", "saturated", v, 32'd0);
        rd(4'd4, v); check("R7", "data flag again", v, 32'hC);

        // R8 stop after data runs out
        wr(4'd4, 32'hFFFFFFFF);
        wr(4'd3, 32'd8);
        wr(4'd1, 32'h00001234);
        wr(4'd0, 32'h80001251);
        wait_req("R8", idx, arg);
        reply(2'd1, 128'h0);
        rd(4'd4, v); check("R8", "no stop before drain", v, 32'h4);
        no_req("R8", 3);
        strobe();
        strobe();
        wait_req("R8", idx, arg);
        check("R8", "stop index", 32'(idx), 32'd12);
        check("R8", "stop argument", arg, 32'd0);
        reply(2'd1, 128'h0);
        rd(4'd4, v); check("R8", "stop done flag", v, 32'h400C);
        rd(4'd0, v); check("R8", "cmd restored", v, 32'h00001251);
        rd(4'd1, v); check("R8", "arg restored", v, 32'h00001234);
        rd(4'd0, v);

        // R8 stop right after the command when counter already zero
        wr(4'd4, 32'hFFFFFFFF);
        wr(4'd3, 32'd0);
        wr(4'd0, 32'h80001046);
        wait_req("R8", idx, arg);
        check("R8", "user index", 32'(idx), 32'd6);
        reply(2'd1, 128'h0);
        wait_req("R8", idx, arg);
        check("R8", "immediate stop index", 32'(idx), 32'd12);
        reply(2'd1, 128'h0);
        rd(4'd4, v); check("R8", "immediate stop flag", v, 32'h4004);
        wr(4'd3, 32'h200);

        // R9 writes ignored while busy
        wr(4'd1, 32'h0000AAAA);
        wr(4'd0, 32'h80000045);
        wait_req("R9", idx, arg);
        wr(4'd0, 32'h80000049);
        wr(4'd1, 32'h00000009);
        check("R9", "index held", 32'(cc_req_index), 32'd5);
        reply(2'd1, 128'h0);
        rd(4'd0, v); check("R9", "cmd unchanged", v, 32'h00000045);
        rd(4'd1, v); check("R9", "arg unchanged", v, 32'h0000AAAA);
        no_req("R9", 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule